// File: doc/BRIEF.md
# SDRAM Mode Register Programmer

This block writes the operating mode of an SDRAM device: the CAS latency, the burst ordering (sequential or interleaved) and the burst length. A requester asserts `req_valid` with the three fields and holds them until `req_ack` pulses. The block latches the fields when it accepts the request. It then waits until every bank reports idle and drives the Mode Register Set command (chip select, RAS, CAS and WE all low) for one clock, with the fields packed onto the address pins. After the settle time it acknowledges the request.

The same path serves the first programming during initialization and any later rewrite at run time. The mode contents are treated as unknown after reset. A sticky `configured` flag rises only when the first programming completes. Until then, write requests from neighbouring logic are held back at `user_wr_out`. Power-up delay, precharge-all and refresh, which come before programming, are handled elsewhere.

Top module: `sdr_modereg_prog`

## Requirements
- R1: While and right after reset, the command outputs show NOP (`cmd_cs_n`=0, `cmd_ras_n`=1, `cmd_cas_n`=1, `cmd_we_n`=1), `cmd_addr` is zero, `req_ack` is 0 and `configured` is 0.
- R2: Each accepted request produces exactly one Mode Register Set cycle, with all four command lines low. Every other cycle carries NOP, including cycles with no request pending.
- R3: In the command cycle, `cmd_addr[2:0]` holds the burst length code, `cmd_addr[3]` the ordering (1 = interleaved) and `cmd_addr[6:4]` the CAS latency code. Every other address bit, A10 included, is 0. Outside the command cycle `cmd_addr` is all zero.
- R4: The command is never driven in a cycle where any bit of `bank_idle` is 0.
- R5: A request accepted while some bank is busy stays pending for as long as needed and is not dropped. The command goes out in the first cycle that `bank_idle` is all ones.
- R6: `req_ack` is high for exactly one cycle, SETTLE_CYCLES+1 cycles after the command cycle. With the default of 1, the cycle after the command is NOP with `req_ack` low, and the cycle after that has `req_ack` high.
- R7: `configured` is 0 after reset and rises in the acknowledge cycle of the first programming. It then stays 1 until the next reset.
- R8: `user_wr_out` is 0 while `configured` is 0 and equals `user_wr_in` once `configured` is 1.
- R9: The fields are captured in the acceptance cycle, which is the first rising edge where `req_valid` is seen while the block is free. Changes on the request field inputs after that do not alter the address driven in the command cycle.
- R10: A later request rewrites the mode with its own fields, and `configured` stays high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Programming request, held until `req_ack` |
| req_cas_lat | input | 3 | CAS latency code |
| req_interleave | input | 1 | 1 = interleaved burst ordering, 0 = sequential |
| req_burst | input | 3 | Burst length code |
| req_ack | output | 1 | One-cycle completion pulse |
| bank_idle | input | NUM_BANKS | One bit per bank, 1 = bank idle |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_addr | output | ADDR_W | Address pins carrying mode data |
| configured | output | 1 | Mode has been written since reset |
| user_wr_in | input | 1 | Write request from neighbouring logic |
| user_wr_out | output | 1 | Write request passed on once configured |

## Verification
A sequencer stuck in its waiting state shows up at the ports as a missing command, followed by a missing `req_ack` in the cycle the bench expects it. An early exit from that state shows up as a command driven while a bank bit is low, in the very cycle it happens. A miscounted settle time moves the acknowledge pulse by one or more cycles and is caught on the first request. Wrong field latching or packing shows up as a wrong `cmd_addr` in the command cycle. It is caught at once, because the bench scrambles the request inputs before that cycle. A broken `configured` register is visible through `user_wr_out` both before and after the first programming.

// File: rtl/mrp_pkg.sv
package mrp_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    localparam int BL_W  = 3;
    localparam int CL_W  = 3;
    localparam int BL_LO = 0;
    localparam int ORD_BIT = BL_LO + BL_W;
    localparam int CL_LO = ORD_BIT + 1;
    localparam int FIELD_TOP = CL_LO + CL_W;

    typedef struct packed {
        logic [CL_W-1:0] cas_lat;
        logic            interleave;
        logic [BL_W-1:0] burst_len;
    } mode_fields_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_SETTLE,
        SQ_ACK
    } seq_state_e;

    function automatic logic is_mrs(input sdr_cmd_t c);
        return (c == CMD_MRS);
    endfunction

endpackage

// File: rtl/mrp_idle_gate.sv
module mrp_idle_gate #(
    parameter int NUM_BANKS = 4
) (
    input  logic [NUM_BANKS-1:0] bank_idle,
    output logic                 all_idle
);
    logic [NUM_BANKS:0] chain;

    assign chain[0] = 1'b1;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign chain[g+1] = chain[g] & bank_idle[g];
    end

    assign all_idle = chain[NUM_BANKS];
endmodule

// File: rtl/mrp_field_pack.sv
module mrp_field_pack
    import mrp_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  mode_fields_t      fields,
    output logic [ADDR_W-1:0] addr_word
);
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        if (b < ORD_BIT) begin : g_bl
            assign addr_word[b] = fields.burst_len[b-BL_LO];
        end else if (b == ORD_BIT) begin : g_ord
            assign addr_word[b] = fields.interleave;
        end else if (b < FIELD_TOP) begin : g_cl
            assign addr_word[b] = fields.cas_lat[b-CL_LO];
        end else begin : g_zero
            assign addr_word[b] = 1'b0;
        end
    end
endmodule

// File: rtl/mrp_seq.sv
module mrp_seq
    import mrp_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  mode_fields_t req_fields,
    input  logic         all_idle,
    output logic         issue,
    output logic         req_ack,
    output logic         configured,
    output mode_fields_t held_fields
);
    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             settle_done;

    assign settle_done = (state_q == SQ_SETTLE) && (cnt_q == CNT_LAST);

    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_IDLE:   if (req_valid) state_d = SQ_WAIT;
            SQ_WAIT:   if (all_idle)  state_d = SQ_SETTLE;
            SQ_SETTLE: if (settle_done) state_d = SQ_ACK;
            SQ_ACK:    state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    assign issue   = (state_q == SQ_WAIT) && all_idle;
    assign req_ack = (state_q == SQ_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SQ_IDLE;
            cnt_q       <= '0;
            configured  <= 1'b0;
            held_fields <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_IDLE && req_valid) begin
                held_fields <= req_fields;
            end
            if (state_q == SQ_SETTLE) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
            if (settle_done) begin
                configured <= 1'b1;
            end
        end
    end

    // R5: a pending request survives busy banks
    assert_pending_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_WAIT && !all_idle) |=> (state_q == SQ_WAIT));

    // R6: acknowledge lasts one cycle
    assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    // R9: held fields only move on acceptance
    assert_fields_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q != SQ_IDLE) |=> $stable(held_fields));
endmodule

// File: rtl/sdr_modereg_prog.sv
module sdr_modereg_prog
    import mrp_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int ADDR_W        = 12,
    parameter int SETTLE_CYCLES = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [2:0]           req_cas_lat,
    input  logic                 req_interleave,
    input  logic [2:0]           req_burst,
    output logic                 req_ack,
    input  logic [NUM_BANKS-1:0] bank_idle,
    output logic                 cmd_cs_n,
    output logic                 cmd_ras_n,
    output logic                 cmd_cas_n,
    output logic                 cmd_we_n,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic                 configured,
    input  logic                 user_wr_in,
    output logic                 user_wr_out
);
    mode_fields_t      req_fields;
    mode_fields_t      held_fields;
    logic              all_idle;
    logic              issue;
    logic [ADDR_W-1:0] packed_word;
    sdr_cmd_t          cmd;

    assign req_fields = '{cas_lat: req_cas_lat, interleave: req_interleave, burst_len: req_burst};

    mrp_idle_gate #(.NUM_BANKS(NUM_BANKS)) u_gate (
        .bank_idle (bank_idle),
        .all_idle  (all_idle)
    );

    mrp_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_fields  (req_fields),
        .all_idle    (all_idle),
        .issue       (issue),
        .req_ack     (req_ack),
        .configured  (configured),
        .held_fields (held_fields)
    );

    mrp_field_pack #(.ADDR_W(ADDR_W)) u_pack (
        .fields    (held_fields),
        .addr_word (packed_word)
    );

    assign cmd       = issue ? CMD_MRS : CMD_NOP;
    assign cmd_cs_n  = cmd.cs_n;
    assign cmd_ras_n = cmd.ras_n;
    assign cmd_cas_n = cmd.cas_n;
    assign cmd_we_n  = cmd.we_n;
    assign cmd_addr  = issue ? packed_word : '0;

    assign user_wr_out = user_wr_in & configured;

    logic mrs_seen;
    assign mrs_seen = is_mrs(cmd);

    // R4: command only with every bank idle
    assert_mrs_needs_idle_R4: assert property (@(posedge clk) disable iff (rst)
        mrs_seen |-> (&bank_idle));

    // R2: a single command cycle per programming
    assert_single_mrs_R2: assert property (@(posedge clk) disable iff (rst)
        mrs_seen |=> !mrs_seen);

    // R3: upper address bits stay low in the command cycle
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        mrs_seen |-> ((cmd_addr >> FIELD_TOP) == '0));

    // R6: no acknowledge in the cycle right after the command
    assert_settle_gap_R6: assert property (@(posedge clk) disable iff (rst)
        mrs_seen |=> !req_ack);

    // R7: configured never falls without reset
    assert_configured_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        configured |=> configured);

    // R8: writes pass only once configured
    assert_wr_gate_R8: assert property (@(posedge clk) disable iff (rst)
        user_wr_out |-> configured);
endmodule

// File: tb/sdr_modereg_prog_test.sv
module sdr_modereg_prog_test;
    localparam int NB = 4;
    localparam int AW = 12;
    localparam logic [3:0] NOP4 = 4'b0111;
    localparam logic [3:0] MRS4 = 4'b0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_cas_lat = '0;
    logic          req_interleave = 1'b0;
    logic [2:0]    req_burst = '0;
    logic          req_ack;
    logic [NB-1:0] bank_idle = '1;
    logic          cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [AW-1:0] cmd_addr;
    logic          configured;
    logic          user_wr_in = 1'b0;
    logic          user_wr_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdr_modereg_prog #(.NUM_BANKS(NB), .ADDR_W(AW), .SETTLE_CYCLES(1)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cas_lat(req_cas_lat),
        .req_interleave(req_interleave), .req_burst(req_burst), .req_ack(req_ack),
        .bank_idle(bank_idle), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
        .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_addr(cmd_addr),
        .configured(configured), .user_wr_in(user_wr_in), .user_wr_out(user_wr_out)
    );

    typedef struct packed {
        logic [2:0]  cas;
        logic        il;
        logic [2:0]  bl;
        logic [3:0]  busy_mask;
        logic [7:0]  busy_cycles;
        logic [11:0] exp_addr;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{cas: 3'd2, il: 1'b0, bl: 3'd3, busy_mask: 4'b1111, busy_cycles: 8'd0, exp_addr: 12'h023},
        '{cas: 3'd3, il: 1'b1, bl: 3'd1, busy_mask: 4'b1110, busy_cycles: 8'd2, exp_addr: 12'h039},
        '{cas: 3'd2, il: 1'b1, bl: 3'd7, busy_mask: 4'b1101, busy_cycles: 8'd3, exp_addr: 12'h02F},
        '{cas: 3'd3, il: 1'b0, bl: 3'd0, busy_mask: 4'b1011, busy_cycles: 8'd1, exp_addr: 12'h030},
        '{cas: 3'd2, il: 1'b0, bl: 3'd2, busy_mask: 4'b0111, busy_cycles: 8'd4, exp_addr: 12'h022},
        '{cas: 3'd1, il: 1'b1, bl: 3'd2, busy_mask: 4'b0000, busy_cycles: 8'd2, exp_addr: 12'h01A}
    };

    function automatic logic [3:0] cmd4();
        return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic program_one(input vec_t v);
        @(negedge clk);
        req_cas_lat    = v.cas;
        req_interleave = v.il;
        req_burst      = v.bl;
        req_valid      = 1'b1;
        bank_idle      = (v.busy_cycles == 0) ? 4'hF : v.busy_mask;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < int'(v.busy_cycles); i++) begin
            chk("R4", "cmd while bank busy", cmd4(), NOP4);
            chk("R5", "ack while pending", req_ack, 0);
            @(negedge clk);
        end
        bank_idle      = '1;
        req_cas_lat    = ~v.cas;
        req_interleave = ~v.il;
        req_burst      = ~v.bl;
        #1;
        chk("R5", "cmd once idle", cmd4(), MRS4);
        chk("R3", "packed address", cmd_addr, v.exp_addr);
        chk("R9", "A3 from captured ordering", cmd_addr[3], v.il);
        @(negedge clk);
        chk("R2", "cmd after command cycle", cmd4(), NOP4);
        chk("R3", "address after command", cmd_addr, 0);
        chk("R6", "ack in settle cycle", req_ack, 0);
        @(negedge clk);
        chk("R6", "ack pulse", req_ack, 1);
        chk("R7", "configured at ack", configured, 1);
        chk("R2", "cmd in ack cycle", cmd4(), NOP4);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R6", "ack drops", req_ack, 0);
        chk("R10", "configured kept", configured, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R5 watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        user_wr_in = 1'b1;
        #1;
        chk("R1", "cmd in reset", cmd4(), NOP4);
        chk("R1", "addr in reset", cmd_addr, 0);
        chk("R1", "ack in reset", req_ack, 0);
        chk("R1", "configured in reset", configured, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "configured after reset", configured, 0);
        chk("R8", "write blocked before config", user_wr_out, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R2", "no command without request", cmd4(), NOP4);
        end

        // vector table; entries after the first are run-time rewrites (R10)
        for (int k = 0; k < NV; k++) begin
            program_one(VECS[k]);
            if (k == 0) begin
                chk("R8", "write passes after config", user_wr_out, 1);
            end
        end

        user_wr_in = 1'b0;
        #1;
        chk("R8", "write follows input low", user_wr_out, 0);
        user_wr_in = 1'b1;

        // long busy window: request must stay pending (R5)
        program_one('{cas: 3'd3, il: 1'b1, bl: 3'd3, busy_mask: 4'b1010,
                      busy_cycles: 8'd40, exp_addr: 12'h03B});

        // reset while a request waits on busy banks
        @(negedge clk);
        req_cas_lat = 3'd2; req_interleave = 1'b0; req_burst = 3'd1;
        req_valid = 1'b1;
        bank_idle = 4'b0110;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R7", "configured cleared by reset", configured, 0);
        chk("R1", "cmd during reset", cmd4(), NOP4);
        chk("R8", "write blocked after reset", user_wr_out, 0);
        req_valid = 1'b0;
        bank_idle = '1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", "no stale command after reset", cmd4(), NOP4);
            chk("R1", "no stale ack after reset", req_ack, 0);
        end

        // first programming after reset restores configured
        program_one('{cas: 3'd2, il: 1'b0, bl: 3'd1, busy_mask: 4'b1111,
                      busy_cycles: 8'd0, exp_addr: 12'h021});
        chk("R8", "write passes again", user_wr_out, 1);

        finish_run();
    end
endmodule